// File: doc/BRIEF.md
# Dimension-Order Mesh Router

This block switches packets at one node of a two-dimensional mesh or torus. Every packet begins with a header flit that carries two signed hop counts, one for X and one for Y. Each count gives the remaining distance to the destination. At every hop the router picks an output from the header and moves one count a single step toward zero. It then forwards the rewritten header and the rest of the packet on that output. X is always resolved completely before any Y movement. A header with both counts at zero leaves through the local port.

There are five input and five output channels, each with a valid/ready handshake. Flits pass from input to output combinationally, and the router has no flit storage. When several inputs compete for one output, a round-robin arbiter for that output chooses the winner. The output then stays reserved for that input until the packet's last flit has gone through. An input that is not granted keeps its flit in place, and its ready stays low.

Top module: `mesh_dor_router`

## Requirements
- R1: Flit format:
  - Bit FLIT_W-1 is the tail flag, which marks the last flit of a packet.
  - The first flit presented on an input after a tail flit, or after reset, is the header.
  - The X offset is header bits [7:4] and the Y offset is bits [3:0]. Both are 4-bit two's complement.
  - Port index 0 is local, 1 is +X, 2 is -X, 3 is +Y and 4 is -Y.
  - Every flit of every packet leaves on some output, in the order it entered.
- R2: When the X offset is positive, the header goes to +X with X reduced by 1. When it is negative, the header goes to -X with X increased by 1. In both cases the Y field and all other bits are unchanged.
- R3: When the X offset is zero and Y is positive, the header goes to +Y with Y reduced by 1. When X is zero and Y is negative, it goes to -Y with Y increased by 1.
- R4: A header whose X and Y offsets are both zero goes to the local port unmodified.
- R5: Flits after the header follow the header's output and pass through unmodified.
- R6: At most one input drives each output. Among competing headers the winner is chosen round-robin. After input k is granted, the search for the next winner starts at input k+1, wrapping after 4. Each pointer starts at input 0 after reset.
- R7: Once an output grants a multi-flit packet, it serves only that input until the packet's tail flit has transferred. This holds even while the owning input has no valid flit.
- R8: An input that is not granted, or whose output is stalled, sees ready low. Ready is never high without valid. While an output is valid and not ready, it keeps its valid and flit unchanged.
- R9: During and directly after reset, no output is valid and no input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 5 | Per-input flit valid |
| in_ready_o | output | 5 | Per-input flit accepted |
| in_flit_i | input | 5*FLIT_W | Input flits, input k at bits [k*FLIT_W +: FLIT_W] |
| out_valid_o | output | 5 | Per-output flit valid |
| out_ready_i | input | 5 | Per-output downstream ready |
| out_flit_o | output | 5*FLIT_W | Output flits, output k at bits [k*FLIT_W +: FLIT_W] |

## Verification
The hardest case to reach is an output that is reserved by a multi-flit packet while its owner has a gap between flits and another input's header is waiting for the same output. From the ports this looks like silence, and the wrong answer is for the waiting packet to slip in and be interleaved. A directed sequence builds this case on purpose. It uses two inputs aimed at +X, stalls the output on the header, and drops the owner's valid for one cycle before the tail arrives. The randomized phase then mixes packet lengths, random output back-pressure and idle gaps on all five inputs. A per-output ownership tracker flags any interleaving, and per-input sequence tags flag any loss or reordering.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int N_PORTS = 5;

  typedef enum logic [2:0] {
    PORT_L  = 3'd0,
    PORT_XP = 3'd1,
    PORT_XM = 3'd2,
    PORT_YP = 3'd3,
    PORT_YM = 3'd4
  } port_e;
endpackage

// File: rtl/rt_input.sv
module rt_input
  import rt_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FLIT_W-1:0]  flit_i,
  input  logic               xfer_i,
  output logic [N_PORTS-1:0] req_o,
  output logic [FLIT_W-1:0]  flit_o,
  output logic               tail_o
);
  localparam int HDR_W = 2 * OFF_W;
  localparam logic signed [OFF_W-1:0] ZERO = '0;
  localparam logic signed [OFF_W-1:0] ONE  = OFF_W'(1);

  logic active_q;
  port_e port_q, port_d, port_sel;
  logic signed [OFF_W-1:0] x_in, y_in, x_nx, y_nx;

  assign x_in   = flit_i[HDR_W-1:OFF_W];
  assign y_in   = flit_i[OFF_W-1:0];
  assign tail_o = flit_i[FLIT_W-1];

  // strict X-then-Y step toward zero
  always_comb begin
    x_nx   = x_in;
    y_nx   = y_in;
    port_d = PORT_L;
    if (x_in > ZERO) begin
      port_d = PORT_XP;
      x_nx   = x_in - ONE;
    end else if (x_in < ZERO) begin
      port_d = PORT_XM;
      x_nx   = x_in + ONE;
    end else if (y_in > ZERO) begin
      port_d = PORT_YP;
      y_nx   = y_in - ONE;
    end else if (y_in < ZERO) begin
      port_d = PORT_YM;
      y_nx   = y_in + ONE;
    end
  end

  assign port_sel = active_q ? port_q : port_d;
  assign req_o    = valid_i ? (N_PORTS'(1) << port_sel) : '0;
  assign flit_o   = active_q ? flit_i : {flit_i[FLIT_W-1:HDR_W], x_nx, y_nx};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      port_q   <= PORT_L;
    end else if (xfer_i) begin
      if (!active_q && !tail_o) begin
        active_q <= 1'b1;
        port_q   <= port_d;
      end else if (active_q && tail_o) begin
        active_q <= 1'b0;
      end
    end
  end

  assert_x_first_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !active_q && x_in != ZERO
      |-> (req_o[PORT_XP] || req_o[PORT_XM]) && flit_o[OFF_W-1:0] == y_in);

  assert_local_clean_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !active_q && x_in == ZERO && y_in == ZERO
      |-> req_o[PORT_L] && flit_o == flit_i);

  assert_body_verbatim_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && active_q |-> flit_o == flit_i && $onehot(req_o));
endmodule

// File: rtl/rt_out_arb.sv
module rt_out_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] tail_i,
  input  logic         ready_i,
  output logic [N-1:0] gnt_o
);
  localparam int IDX_W = $clog2(N);

  logic             locked_q, found;
  logic [IDX_W-1:0] owner_q, ptr_q, pick;

  // rotating-priority search starting at ptr_q
  always_comb begin
    found = 1'b0;
    pick  = ptr_q;
    for (int k = 0; k < N; k++) begin
      automatic int idx = (int'(ptr_q) + k) % N;
      if (!found && req_i[idx]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    if (locked_q) gnt_o[owner_q] = req_i[owner_q];
    else if (found) gnt_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= '0;
    end else if (!locked_q) begin
      if (found) begin
        ptr_q <= (int'(pick) == N - 1) ? '0 : pick + 1'b1;
        if (!(ready_i && tail_i[pick])) begin
          locked_q <= 1'b1;
          owner_q  <= pick;
        end
      end
    end else if (req_i[owner_q] && ready_i && tail_i[owner_q]) begin
      locked_q <= 1'b0;
    end
  end

  assert_single_grant_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));

  assert_lock_kept_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q && !(req_i[owner_q] && ready_i && tail_i[owner_q])
      |=> locked_q && owner_q == $past(owner_q));
endmodule

// File: rtl/mesh_dor_router.sv
module mesh_dor_router
  import rt_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int OFF_W  = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  output logic [N_PORTS-1:0]          in_ready_o,
  input  logic [N_PORTS*FLIT_W-1:0]   in_flit_i,
  output logic [N_PORTS-1:0]          out_valid_o,
  input  logic [N_PORTS-1:0]          out_ready_i,
  output logic [N_PORTS*FLIT_W-1:0]   out_flit_o
);
  logic [N_PORTS-1:0] req [N_PORTS];  // req[in][out]
  logic [N_PORTS-1:0] gnt [N_PORTS];  // gnt[out][in]
  logic [FLIT_W-1:0]  fwd [N_PORTS];
  logic [N_PORTS-1:0] tail, xfer;

  assign xfer = in_valid_i & in_ready_o;

  for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_in
    rt_input #(.FLIT_W(FLIT_W), .OFF_W(OFF_W)) u_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(in_valid_i[gi]),
      .flit_i (in_flit_i[gi*FLIT_W +: FLIT_W]),
      .xfer_i (xfer[gi]),
      .req_o  (req[gi]),
      .flit_o (fwd[gi]),
      .tail_o (tail[gi])
    );

    assert_ready_has_valid_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o[gi] |-> in_valid_i[gi]);
  end

  for (genvar go = 0; go < N_PORTS; go++) begin : g_out
    logic [N_PORTS-1:0] col;
    logic [FLIT_W-1:0]  mux;

    always_comb begin
      for (int i = 0; i < N_PORTS; i++) col[i] = req[i][go];
    end

    rt_out_arb #(.N(N_PORTS)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (col),
      .tail_i (tail),
      .ready_i(out_ready_i[go]),
      .gnt_o  (gnt[go])
    );

    always_comb begin
      mux = '0;
      for (int i = 0; i < N_PORTS; i++) if (gnt[go][i]) mux = mux | fwd[i];
    end

    assign out_valid_o[go]                    = |gnt[go];
    assign out_flit_o[go*FLIT_W +: FLIT_W]    = mux;

    assert_stall_hold_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[go] && !out_ready_i[go]
        |=> out_valid_o[go] && $stable(out_flit_o[go*FLIT_W +: FLIT_W]));
  end

  always_comb begin
    in_ready_o = '0;
    for (int i = 0; i < N_PORTS; i++)
      for (int o = 0; o < N_PORTS; o++)
        in_ready_o[i] = in_ready_o[i] | (gnt[o][i] & out_ready_i[o]);
  end
endmodule

// File: tb/mesh_dor_router_tb.sv
module mesh_dor_router_tb;
  import rt_pkg::*;
  localparam int FW = 16;
  localparam int OW = 4;
  localparam int NP = N_PORTS;
  localparam int MAXF = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [NP*FW-1:0] in_flit, out_flit;

  mesh_dor_router #(.FLIT_W(FW), .OFF_W(OW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_flit_i(in_flit),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_flit_o(out_flit)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic logic [FW-1:0] mk(logic t, int id, int seq, logic [7:0] low);
    return {t, 3'(id), 4'(seq), low};
  endfunction

  function automatic int ref_port(logic [7:0] low);
    logic signed [3:0] x, y;
    x = low[7:4]; y = low[3:0];
    if (x > 4'sd0) return 1;
    if (x < 4'sd0) return 2;
    if (y > 4'sd0) return 3;
    if (y < 4'sd0) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] ref_low(logic [7:0] low);
    logic signed [3:0] x, y;
    x = low[7:4]; y = low[3:0];
    if (x > 4'sd0) x = x - 4'sd1;
    else if (x < 4'sd0) x = x + 4'sd1;
    else if (y > 4'sd0) y = y - 4'sd1;
    else if (y < 4'sd0) y = y + 4'sd1;
    return {x, y};
  endfunction

  task automatic set_in(int i, logic v, logic [FW-1:0] f);
    in_valid[i] = v;
    in_flit[i*FW +: FW] = f;
  endtask

  task automatic dir_case(string tag, logic [7:0] low, int port, logic [7:0] exp_low);
    @(negedge clk);
    set_in(2, 1'b1, mk(1'b1, 2, 0, low));
    #2;
    check({tag, " port"}, 32'(out_valid), 32'(1 << port));
    check({tag, " header"}, 32'(out_flit[port*FW +: FW]), 32'(mk(1'b1, 2, 0, exp_low)));
    @(negedge clk);
    set_in(2, 1'b0, '0);
  endtask

  logic [FW-1:0] src_f [NP][MAXF];
  logic [FW-1:0] exp_f [NP][MAXF];
  int dst [NP][MAXF];
  int cnt [NP];
  int sent [NP];
  int rx [NP];
  int own [NP];
  logic [NP-1:0] acc;
  logic [NP-1:0] stall_prev;
  logic [FW-1:0] stall_flit [NP];

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    void'($urandom(32'd7719));
    in_valid = '0; in_flit = '0; out_ready = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 valid in reset", 32'(out_valid), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk); #2;
    check("R9 out_valid after reset", 32'(out_valid), 32'd0);
    check("R9 in_ready after reset", 32'(in_ready), 32'd0);

    // R6 round robin on local output
    out_ready = '1;
    set_in(1, 1'b1, mk(1'b1, 1, 0, 8'h00));
    set_in(2, 1'b1, mk(1'b1, 2, 0, 8'h00));
    set_in(3, 1'b1, mk(1'b1, 3, 0, 8'h00));
    #2;
    check("R6 first winner", 32'(in_ready), 32'b00010);
    check("R4 local flit", 32'(out_flit[0 +: FW]), 32'(mk(1'b1, 1, 0, 8'h00)));
    check("R4 local only", 32'(out_valid), 32'b00001);
    @(negedge clk); set_in(1, 1'b0, '0); #2;
    check("R6 second winner", 32'(in_ready), 32'b00100);
    @(negedge clk); set_in(2, 1'b0, '0); #2;
    check("R6 third winner", 32'(in_ready), 32'b01000);
    @(negedge clk); set_in(3, 1'b0, '0);
    set_in(0, 1'b1, mk(1'b1, 0, 0, 8'h00));
    set_in(4, 1'b1, mk(1'b1, 4, 0, 8'h00));
    #2;
    check("R6 pointer past 3 picks 4", 32'(in_ready), 32'b10000);
    @(negedge clk); set_in(4, 1'b0, '0); #2;
    check("R6 wrap to 0", 32'(in_ready), 32'b00001);
    @(negedge clk); set_in(0, 1'b0, '0);

    // R7/R8 lock with stall and owner gap
    out_ready = 5'b11101;
    set_in(0, 1'b1, mk(1'b0, 0, 0, 8'h10));
    set_in(4, 1'b1, mk(1'b1, 4, 0, 8'h32));
    #2;
    check("R2 +X header rewrite", 32'(out_flit[1*FW +: FW]), 32'(mk(1'b0, 0, 0, 8'h00)));
    check("R8 stalled output ready", 32'(in_ready), 32'd0);
    @(negedge clk); #2;
    check("R8 stalled flit held", 32'(out_flit[1*FW +: FW]), 32'(mk(1'b0, 0, 0, 8'h00)));
    check("R8 stalled valid held", 32'(out_valid[1]), 32'd1);
    @(negedge clk); out_ready = '1; #2;
    check("R7 owner only", 32'(in_ready), 32'b00001);
    @(negedge clk); set_in(0, 1'b0, '0); #2;
    check("R7 gap keeps lock", 32'(in_ready), 32'd0);
    check("R7 gap output idle", 32'(out_valid[1]), 32'd0);
    @(negedge clk); set_in(0, 1'b1, mk(1'b1, 0, 1, 8'h5A)); #2;
    check("R5 tail verbatim", 32'(out_flit[1*FW +: FW]), 32'(mk(1'b1, 0, 1, 8'h5A)));
    check("R7 owner tail accepted", 32'(in_ready), 32'b00001);
    @(negedge clk); set_in(0, 1'b0, '0); #2;
    check("R7 waiter after release", 32'(in_ready), 32'b10000);
    check("R2 waiter rewrite", 32'(out_flit[1*FW +: FW]), 32'(mk(1'b1, 4, 0, 8'h22)));
    @(negedge clk); set_in(4, 1'b0, '0);

    dir_case("R2 -X at -8", 8'h85, 2, 8'h95);
    dir_case("R3 +Y at 7", 8'h07, 3, 8'h06);
    dir_case("R3 -Y at -8", 8'h08, 4, 8'h09);
    dir_case("R3 -Y at -1", 8'h0F, 4, 8'h00);

    // randomized traffic
    for (int i = 0; i < NP; i++) begin
      cnt[i] = 0; sent[i] = 0; rx[i] = 0; own[i] = -1;
      while (cnt[i] + 4 <= 48) begin
        automatic int len = 1 + int'($urandom % 4);
        automatic logic [3:0] xo = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom % 16);
        automatic logic [3:0] yo = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom % 16);
        automatic int p = ref_port({xo, yo});
        for (int k = 0; k < len; k++) begin
          automatic logic [7:0] low = (k == 0) ? {xo, yo} : 8'($urandom);
          src_f[i][cnt[i]] = mk(k == len - 1, i, cnt[i] % 16, low);
          exp_f[i][cnt[i]] = (k == 0) ? mk(k == len - 1, i, cnt[i] % 16, ref_low(low))
                                      : src_f[i][cnt[i]];
          dst[i][cnt[i]] = p;
          cnt[i]++;
        end
      end
    end
    acc = '0; stall_prev = '0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      automatic bit done = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
        if (in_valid[i] && acc[i]) sent[i]++;
        if (!(in_valid[i] && !acc[i])) begin
          if (sent[i] < cnt[i] && ($urandom % 4 != 0)) set_in(i, 1'b1, src_f[i][sent[i]]);
          else set_in(i, 1'b0, '0);
        end
        if (rx[i] < cnt[i]) done = 1'b0;
      end
      if (done) break;
      out_ready = 5'($urandom);
      #2;
      acc = in_ready & in_valid;
      for (int o = 0; o < NP; o++) begin
        automatic logic [FW-1:0] f = out_flit[o*FW +: FW];
        if (stall_prev[o]) begin
          check("R8 random stall hold", 32'({out_valid[o], f}), 32'({1'b1, stall_flit[o]}));
        end
        stall_prev[o] = out_valid[o] && !out_ready[o];
        stall_flit[o] = f;
        if (out_valid[o] && out_ready[o]) begin
          automatic int id = int'(f[14:12]);
          if (id >= NP) begin
            check("R1 flit source id", 32'(id), 32'(NP - 1));
          end else begin
            check("R2 R3 R4 R5 output port", 32'(o), 32'(dst[id][rx[id]]));
            check("R2 R3 R4 R5 flit value", 32'(f), 32'(exp_f[id][rx[id]]));
            if (own[o] != -1) check("R7 no interleave", 32'(id), 32'(own[o]));
            own[o] = f[FW-1] ? -1 : id;
            rx[id]++;
          end
        end
      end
    end
    for (int i = 0; i < NP; i++) check("R1 all flits delivered", 32'(rx[i]), 32'(cnt[i]));
    report();
  end
endmodule